// File: doc/BRIEF.md
# Two-Channel External Interrupt Controller

This block watches two external pins for a selected event and turns those events into prioritised interrupt requests for a small 8-bit processor core. Each pin goes through a two-flop synchroniser. It is then compared with its previous synchronised sample, so that a two-bit sense field per channel can select rising-edge, falling-edge or low-level triggering. The detector looks only at the pin value, so activity on a pin that the core drives as an output still raises an event.

A detected event sets that channel's pending flag whether or not the channel is enabled. Software reaches a mask register and a flag register through an 8-bit register bus with 6-bit I/O addresses. A flag is cleared in one of two ways: software writes a one to its bit, or the core acknowledges the vector that the block is presenting. A request is presented only when a channel's flag, its mask bit and the global interrupt enable input are all one. Channel 0 wins when both channels are pending.

Arbitration is a three-state machine. ST_IDLE presents nothing. ST_CH0 presents vector 0x002. ST_CH1 presents vector 0x004. On every clock edge the machine chooses its next state from the flag and mask values being written at that edge and from the global enable:
- take_ch0: any state goes to ST_CH0 when channel 0 is pending.
- take_ch1: any state goes to ST_CH1 when channel 1 is pending and channel 0 is not.
- drop: any state goes to ST_IDLE when nothing is pending.

Because of this, an acknowledge moves the machine on at the same edge that clears the flag.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset both registers read 0x00, no request is presented and the vector output is 0.
- R2: The mask register is at address 0x3B. Bit 6 enables channel 0 and bit 7 enables channel 1. Bits 5..0 ignore writes and read zero. Any other address reads 0x00.
- R3: The flag register is at address 0x3A, with channel 0 at bit 6, channel 1 at bit 7, and bits 5..0 reading zero.
- R4: Sense code 11 (sense_i[1:0] for channel 0, sense_i[3:2] for channel 1) sets the flag on a rising pin edge, and code 10 sets it on a falling edge. The flag reads set after the third clock edge following the pin change, and an edge of the other polarity sets nothing.
- R5: Sense code 00 sets the flag on every cycle in which the synchronised pin is low, so a clear has no lasting effect until the pin is high again.
- R6: Sense code 01 never sets the flag.
- R7: A flag is set by its event even when the channel's mask bit is zero.
- R8: irq_req_o is high only when some channel had flag, mask bit and gie_i all one at the previous clock edge.
- R9: The vector output is 0x002 while channel 0 is presented, 0x004 while channel 1 is presented, and 0 with no request.
- R10: When both channels are pending, channel 0 is presented first.
- R11: irq_ack_i clears the flag of the channel being presented at that edge, and the next pending channel is presented in the following cycle. An acknowledge with no request changes nothing.
- R12: Writing a one to a flag bit at 0x3A clears it, and writing a zero leaves it unchanged.
- R13: An event in the same cycle as a clear (software or acknowledge) leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Raw external pins, bit 0 is channel 0 |
| sense_i | input | 4 | Sense codes: [1:0] channel 0, [3:2] channel 1 |
| gie_i | input | 1 | Global interrupt enable from the core |
| bus_addr_i | input | 6 | Register I/O address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i (combinational) |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 12 | Vector address of the presented channel |
| irq_ack_i | input | 1 | Core takes the presented vector |

## Verification
The assertions check the following on every cycle:
- A request never appears without the global enable at the previous edge.
- Channel 1 is never presented while channel 0 is both flagged and enabled.
- The vector value always matches the request.
- A detected event always leaves its flag set at the next edge, whatever clear arrives at the same time.
- A lone software or acknowledge clear takes effect.
- The no-event sense code never produces an event.

Only the bench scenarios can show the following:
- The exact three-edge latency from a pin change to the flag.
- That edges of the wrong polarity are ignored.
- That a low level keeps re-setting its flag across repeated clears.
- The handover from channel 0 to channel 1 after an acknowledge.
- That an acknowledge with no request leaves the flags untouched.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int unsigned NCH    = 2;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned VEC_W  = 12;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_NONE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CH0  = 2'd1,
        ST_CH1  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] cur_o,
    output logic [NCH-1:0] prev_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic meta_q, cur_q, prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                cur_q  <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= pin_i[c];
                cur_q  <= meta_q;
                prev_q <= cur_q;
            end
        end
        assign cur_o[c]  = cur_q;
        assign prev_o[c] = prev_q;
    end
endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   cur_i,
    input  logic [NCH-1:0]   prev_i,
    input  logic [2*NCH-1:0] sense_i,
    output logic [NCH-1:0]   event_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sense_e mode;
        assign mode = sense_e'(sense_i[2*c +: 2]);
        always_comb begin
            unique case (mode)
                SENSE_LOW:  event_o[c] = ~cur_i[c];
                SENSE_NONE: event_o[c] = 1'b0;
                SENSE_FALL: event_o[c] = prev_i[c] & ~cur_i[c];
                SENSE_RISE: event_o[c] = ~prev_i[c] & cur_i[c];
                default:    event_o[c] = 1'b0;
            endcase
        end

        assert_none_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == SENSE_NONE) |-> !event_o[c]);
    end
endmodule

// File: rtl/eic_regs.sv
module eic_regs #(
    parameter int unsigned NCH       = 2,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    event_i,
    input  logic [NCH-1:0]    hw_clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    flag_q,
    output logic [NCH-1:0]    mask_d,
    output logic [NCH-1:0]    flag_d
);
    localparam int unsigned LSB = DATA_W - NCH;

    logic            mask_we, flag_we;
    logic [NCH-1:0]  sw_clr;

    assign mask_we = wr_i && (addr_i == MASK_ADDR);
    assign flag_we = wr_i && (addr_i == FLAG_ADDR);
    assign sw_clr  = flag_we ? wdata_i[LSB +: NCH] : '0;
    assign mask_d  = mask_we ? wdata_i[LSB +: NCH] : mask_q;
    assign flag_d  = event_i | (flag_q & ~sw_clr & ~hw_clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            flag_q <= '0;
        end else begin
            mask_q <= mask_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == MASK_ADDR)      rdata_o[LSB +: NCH] = mask_q;
        else if (addr_i == FLAG_ADDR) rdata_o[LSB +: NCH] = flag_q;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_event_sets_R13: assert property (@(posedge clk) disable iff (!rst_n)
            event_i[c] |=> flag_q[c]);
        assert_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_we && wdata_i[LSB+c] && !event_i[c]) |=> !flag_q[c]);
    end
endmodule

// File: rtl/eic_arb.sv
module eic_arb
    import eic_pkg::*;
#(
    parameter int unsigned NCH      = 2,
    parameter int unsigned VEC_W    = 12,
    parameter int unsigned VEC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pend_d_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [NCH-1:0]   hw_clr_o
);
    localparam logic [VEC_W-1:0] VEC0 = VEC_W'(VEC_STEP);
    localparam logic [VEC_W-1:0] VEC1 = VEC_W'(2 * VEC_STEP);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (pend_d_i[0])      state_d = ST_CH0;
        else if (pend_d_i[1]) state_d = ST_CH1;
        else                  state_d = ST_IDLE;
    end

    always_comb begin
        req_o    = 1'b0;
        vec_o    = '0;
        hw_clr_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CH0: begin
                req_o       = 1'b1;
                vec_o       = VEC0;
                hw_clr_o[0] = ack_i;
            end
            ST_CH1: begin
                req_o       = 1'b1;
                vec_o       = VEC1;
                hw_clr_o[1] = ack_i;
            end
            default: ;
        endcase
    end

    assert_vec_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o ? (vec_o == VEC0 || vec_o == VEC1) : (vec_o == '0));
    assert_clr_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hw_clr_o));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     pin_i,
    input  logic [2*NCH-1:0]   sense_i,
    input  logic               gie_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_req_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    input  logic               irq_ack_i
);
    logic [NCH-1:0] cur, prev, evt, hw_clr;
    logic [NCH-1:0] mask_q, flag_q, mask_d, flag_d, pend_d;

    eic_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
    );

    eic_detect #(.NCH(NCH)) u_det (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
        .sense_i(sense_i), .event_o(evt)
    );

    eic_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .event_i(evt), .hw_clr_i(hw_clr),
        .addr_i(bus_addr_i), .wr_i(bus_wr_i), .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o), .mask_q(mask_q), .flag_q(flag_q),
        .mask_d(mask_d), .flag_d(flag_d)
    );

    assign pend_d = flag_d & mask_d & {NCH{gie_i}};

    eic_arb #(.NCH(NCH), .VEC_W(VEC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend_d_i(pend_d), .ack_i(irq_ack_i),
        .req_o(irq_req_o), .vec_o(irq_vec_o), .hw_clr_o(hw_clr)
    );

    assert_req_needs_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> $past(gie_i));
    assert_prio_ch0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec_o == VEC_W'(4)) |-> !(flag_q[0] && mask_q[0]));
    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_vec_o == VEC_W'(2) && !evt[0]) |=> !flag_q[0]);
    assert_flag_wo_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] && !mask_q[1]) |=> flag_q[1]);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = 2'b11;
    logic [3:0]  sense = 4'b0101;
    logic        gie = 1'b0;
    logic [5:0]  addr = 6'h3A;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        req;
    logic [11:0] vec;
    logic        ack = 1'b0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_i(sense), .gie_i(gie),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack)
    );

    // Reference model built from the requirements
    logic [1:0] m_s1, m_s2, m_pr, m_mask, m_flag;
    int         m_state;

    function automatic logic ev_of(input logic [1:0] code, input logic cur, input logic prv);
        case (code)
            2'b00:   return !cur;
            2'b10:   return prv && !cur;
            2'b11:   return !prv && cur;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        if (a == 6'h3B) return {m_mask, 6'b0};
        if (a == 6'h3A) return {m_flag, 6'b0};
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 2'b11; m_s2 = 2'b11; m_pr = 2'b11;
            m_mask = 2'b00; m_flag = 2'b00; m_state = 0;
        end else begin
            logic [1:0] nf, nm, p;
            for (int c = 0; c < 2; c++) begin
                logic e, h, s;
                e = ev_of(sense[2*c +: 2], m_s2[c], m_pr[c]);
                h = ack && (m_state == c + 1);
                s = wr && (addr == 6'h3A) && wdata[6+c];
                nf[c] = e | (m_flag[c] & !h & !s);
            end
            nm = (wr && addr == 6'h3B) ? wdata[7:6] : m_mask;
            p  = nf & nm & {2{gie}};
            m_state = p[0] ? 1 : (p[1] ? 2 : 0);
            m_flag = nf; m_mask = nm;
            m_pr = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock, then compare all outputs with the model away from the edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R8 request", 16'(req), 16'(m_state != 0));
        chk("R9 R10 vector", 16'(vec), (m_state == 1) ? 16'h002 : (m_state == 2) ? 16'h004 : 16'h000);
        chk("R2 R3 readback", 16'(rdata), 16'(exp_rd(addr)));
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        addr = a;
        #1;
        chk(tag, 16'(rdata), 16'(e));
    endtask

    task automatic wrr(input logic [5:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycn(3);
        rd(6'h3B, 8'h00, "R1 mask reset");
        rd(6'h3A, 8'h00, "R1 flag reset");
        chk("R1 no request", 16'(req), 16'h0);
        chk("R1 vector zero", 16'(vec), 16'h0);

        wrr(6'h3B, 8'hFF);
        rd(6'h3B, 8'hC0, "R2 mask reserved bits");
        rd(6'h15, 8'h00, "R2 unmapped address");
        wrr(6'h3B, 8'h00);
        rd(6'h3B, 8'h00, "R2 mask cleared");

        // R4 rising edge latency on channel 0, falls ignored
        sense = 4'b1111; pin = 2'b00;
        cycn(4);
        rd(6'h3A, 8'h00, "R4 fall ignored in rise mode");
        pin = 2'b01;
        cycn(2);
        rd(6'h3A, 8'h00, "R4 not yet after two edges");
        cyc();
        rd(6'h3A, 8'h40, "R4 rise sets after third edge");

        wrr(6'h3A, 8'h00);
        rd(6'h3A, 8'h40, "R12 write zero keeps flag");
        wrr(6'h3A, 8'h40);
        rd(6'h3A, 8'h00, "R12 write one clears flag");

        // R4 falling edge on channel 1, mask off (R7)
        sense = 4'b1011; pin = 2'b11;
        cycn(4);
        rd(6'h3A, 8'h00, "R4 rise ignored in fall mode");
        pin = 2'b01;
        cycn(3);
        rd(6'h3A, 8'h80, "R4 R7 fall sets flag with mask off");
        chk("R7 no request with mask off", 16'(req), 16'h0);
        wrr(6'h3A, 8'h80);

        // R6 reserved sense code
        sense = 4'b0101;
        pin = 2'b00; cyc(); pin = 2'b11; cyc(); pin = 2'b00; cyc(); pin = 2'b11;
        cycn(4);
        rd(6'h3A, 8'h00, "R6 code 01 never sets");

        // R5 low level re-sets after clear (R13)
        sense = 4'b0100; pin = 2'b10;
        cycn(3);
        rd(6'h3A, 8'h40, "R5 low level sets");
        wrr(6'h3A, 8'h40);
        rd(6'h3A, 8'h40, "R5 R13 clear loses to level");
        pin = 2'b11;
        cycn(3);
        rd(6'h3A, 8'h40, "R5 flag held after pin high");
        wrr(6'h3A, 8'h40);
        rd(6'h3A, 8'h00, "R5 clear works once high");

        // R11 acknowledge with no request is ignored
        sense = 4'b1101; pin = 2'b01;
        cycn(3);
        pin = 2'b11;
        cycn(3);
        rd(6'h3A, 8'h80, "R4 channel 1 rise");
        ack = 1'b1; cyc(); ack = 1'b0;
        rd(6'h3A, 8'h80, "R11 idle ack ignored");

        // R8 global enable gating
        wrr(6'h3B, 8'h80);
        cyc();
        chk("R8 gie low blocks request", 16'(req), 16'h0);
        gie = 1'b1;
        cyc();
        chk("R8 request with gie", 16'(req), 16'h1);
        chk("R9 channel 1 vector", 16'(vec), 16'h004);

        // R10 priority, R11 acknowledge sequence
        sense = 4'b1111; pin = 2'b10;
        cycn(3);
        pin = 2'b11;
        cycn(3);
        rd(6'h3A, 8'hC0, "R10 both flags");
        chk("R10 ch0 masked keeps ch1", 16'(vec), 16'h004);
        wrr(6'h3B, 8'hC0);
        chk("R10 channel 0 first", 16'(vec), 16'h002);
        ack = 1'b1; cyc(); ack = 1'b0;
        rd(6'h3A, 8'h80, "R11 ack clears channel 0");
        chk("R11 hands over to channel 1", 16'(vec), 16'h004);
        ack = 1'b1; cyc(); ack = 1'b0;
        rd(6'h3A, 8'h00, "R11 ack clears channel 1");
        chk("R11 idle after both", 16'(req), 16'h0);

        // Constrained random phase against the model
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 4000; i++) begin
            int r;
            if (i % 64 == 0) sense = 4'($urandom);
            if ($urandom % 4 == 0) pin[$urandom % 2] = ~pin[$urandom % 2];
            gie = ($urandom % 8) != 0;
            ack = ($urandom % 3) == 0;
            r = $urandom % 4;
            addr = (r == 0) ? 6'h3A : (r == 1) ? 6'h3B : (r == 2) ? 6'h3C : 6'h3A;
            wr = ($urandom % 5) == 0;
            wdata = 8'($urandom);
            cyc();
        end
        wr = 1'b0; ack = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule